// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns single transfers from an internal request port into cycles on an external bus where the low 16 address bits and the data share the same pins. A request carries a 24-bit address, write data, a byte or halfword size and a read/write flag. The block decodes the upper address byte against four programmable chip-select windows. Each window has a granularity of 64 KB and its own data width (8 or 16 bits) and its own wait-state count. The block then runs the bus cycle and returns one response per request.

Every bus cycle has two phases. The first is a one-clock address phase, in which the address strobe is low and the low address is on the shared lines. The second is a data phase, in which the read strobe or the byte write strobes are low. The data phase lasts one clock, plus the window's programmed waits, plus one clock for each ready sample seen low once those waits have run out. A halfword access to an 8-bit window is split into two bus cycles. The windows are programmed through a small configuration write port.

Top module: `mbb_bus_ctrl`

## Requirements
- R1: After reset the block is idle. `req_ready_o`=1. All strobes and chip selects are high. `ad_oe_o`=0, `ad_o`=0, `addr_hi_o`=0 and `rsp_valid_o`=0.
- R2: An accepted request starts with exactly one address-phase clock, one clock after acceptance. In that clock `as_no`=0, `ad_oe_o`=1, `ad_o` carries the low 16 address bits and `addr_hi_o` carries address bits 23:16. With no waits the data phase takes one clock. `rsp_valid_o` pulses for one clock in the clock after the last data-phase clock, and the block is idle again in that clock.
- R3: The data phase of a window programmed with W waits lasts W+1 clocks when ready is high. Ready is ignored during the W wait clocks.
- R4: Once the waits have expired, each clock in which `rdy_i` is sampled low extends the data phase by one clock. The strobes stay asserted until `rdy_i` is sampled high.
- R5: Window i matches when it is enabled and (addr[23:16] & mask_i) == (base_i & mask_i). The lowest-numbered matching window wins. Its active-low chip select `cs_no[i]` is low through the address and data phases, and no other chip select is low.
- R6: An address that matches no enabled window runs a 16-bit, zero-wait cycle with all chip selects high.
- R7: In a 16-bit window, a halfword write drives write data unchanged on `ad_o` with both `wr_no` bits low. A byte write at an even address drives `wr_no[0]` low only. A byte write at an odd address drives `wr_no[1]` low only. In both byte cases the byte is driven on both lanes. A halfword read returns `ad_i`. A byte read returns `ad_i[15:8]` for an even address and `ad_i[7:0]` for an odd address.
- R8: In an 8-bit window, every beat uses `ad_i[15:8]` and `wr_no[0]` only. A halfword access runs two bus cycles, first at the even address carrying data bits 15:8, then at the odd address carrying bits 7:0.
- R9: In a read data phase `rd_no`=0 and `ad_oe_o`=0. Read data is taken only on the last data-phase clock. Byte reads return the byte zero-extended, and writes return `rsp_rdata_o`=0.
- R10: A configuration write takes effect for requests accepted after its clock edge. A request accepted on the same edge is decoded with the old settings.
- R11: For halfword requests, address bit 0 is ignored and driven as 0 in the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Window configuration write |
| cfg_area_i | input | 2 | Window index written |
| cfg_en_i | input | 1 | Window enable |
| cfg_base_i | input | 8 | Window base, address bits 23:16 |
| cfg_mask_i | input | 8 | Compare mask on address bits 23:16 (1 = compared) |
| cfg_wide_i | input | 1 | 1 = 16-bit window, 0 = 8-bit window |
| cfg_wait_i | input | 4 | Programmed wait clocks |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_write_i | input | 1 | 1 = write |
| req_half_i | input | 1 | 1 = halfword, 0 = byte |
| req_addr_i | input | 24 | Byte address |
| req_wdata_i | input | 16 | Write data (byte in bits 7:0) |
| rsp_valid_o | output | 1 | Transfer complete pulse |
| rsp_rdata_o | output | 16 | Read data |
| addr_hi_o | output | 8 | Address bits 23:16 during a cycle |
| ad_o | output | 16 | Shared address/data lines, outgoing |
| ad_oe_o | output | 1 | Output enable of the shared lines |
| ad_i | input | 16 | Shared address/data lines, incoming |
| as_no | output | 1 | Address strobe, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 2 | Write strobes, active low (bit 0 upper lane) |
| cs_no | output | 4 | Chip selects, active low |
| rdy_i | input | 1 | External ready |

## Verification
Two events can fall in the same clock, and the bench provokes both. The first is a configuration write in the same clock in which a request is accepted. The bench changes the wait count of the window being addressed on that edge, and the reference model expects the old count for that transfer and the new count for the next one. The second is the expiry of the programmed waits together with a low ready. The bench toggles ready during the wait clocks, which must be ignored, and then holds it low for several clocks once the waits have expired. The model compares strobes, chip selects, shared lines and the response against the design on every clock of each transfer.

// File: rtl/mbb_pkg.sv
package mbb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} bus_state_e;
  typedef enum logic [1:0] {LANE_BOTH, LANE_UP, LANE_LO} lane_e;
endpackage

// File: rtl/mbb_area_regs.sv
module mbb_area_regs #(
  parameter int N_AREA   = 4,
  parameter int HI_W     = 8,
  parameter int WAIT_W   = 4,
  parameter bit DEF_WIDE = 1'b1,
  localparam int IDX_W   = (N_AREA > 1) ? $clog2(N_AREA) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_area_i,
  input  logic              cfg_en_i,
  input  logic [HI_W-1:0]   cfg_base_i,
  input  logic [HI_W-1:0]   cfg_mask_i,
  input  logic              cfg_wide_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  input  logic [HI_W-1:0]   look_hi_i,
  output logic [N_AREA-1:0] hit_oh_o,
  output logic              wide_o,
  output logic [WAIT_W-1:0] wait_o
);
  logic [N_AREA-1:0] en_q, wide_q, match;
  logic [HI_W-1:0]   base_q [N_AREA];
  logic [HI_W-1:0]   mask_q [N_AREA];
  logic [WAIT_W-1:0] wait_q [N_AREA];

  for (genvar i = 0; i < N_AREA; i++) begin : g_area
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[i]   <= 1'b0;
        wide_q[i] <= 1'b0;
        base_q[i] <= '0;
        mask_q[i] <= '0;
        wait_q[i] <= '0;
      end else if (cfg_we_i && cfg_area_i == IDX_W'(i)) begin
        en_q[i]   <= cfg_en_i;
        wide_q[i] <= cfg_wide_i;
        base_q[i] <= cfg_base_i;
        mask_q[i] <= cfg_mask_i;
        wait_q[i] <= cfg_wait_i;
      end
    end
    assign match[i] = en_q[i] && ((look_hi_i & mask_q[i]) == (base_q[i] & mask_q[i]));
  end

  // lowest index wins
  always_comb begin
    logic found;
    found    = 1'b0;
    hit_oh_o = '0;
    for (int i = 0; i < N_AREA; i++) begin
      if (match[i] && !found) begin
        hit_oh_o[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  always_comb begin
    wide_o = (hit_oh_o == '0) ? DEF_WIDE : 1'b0;
    wait_o = '0;
    for (int i = 0; i < N_AREA; i++) begin
      if (hit_oh_o[i]) begin
        wide_o = wide_q[i];
        wait_o = wait_q[i];
      end
    end
  end

  always_comb begin
    assert_hit_onehot_R5: assert ($onehot0(hit_oh_o));
  end
endmodule

// File: rtl/mbb_lane_steer.sv
module mbb_lane_steer
  import mbb_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int DATA_W = 2 * LANE_W
) (
  input  logic              wide_i,
  input  logic              half_i,
  input  logic              a0_i,
  input  logic              beat_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] bus_i,
  output lane_e             lane_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic [1:0]        wr_act_o,
  output logic [LANE_W-1:0] rd_byte_o
);
  logic [LANE_W-1:0] wbyte;

  always_comb begin
    if (!wide_i)      lane_o = LANE_UP;
    else if (half_i)  lane_o = LANE_BOTH;
    else if (a0_i)    lane_o = LANE_LO;
    else              lane_o = LANE_UP;
  end

  // narrow halfword: upper byte on first beat
  assign wbyte = (half_i && !beat_i) ? wdata_i[DATA_W-1:LANE_W] : wdata_i[LANE_W-1:0];

  always_comb begin
    unique case (lane_o)
      LANE_BOTH: begin bus_wdata_o = wdata_i;        wr_act_o = 2'b11; end
      LANE_LO:   begin bus_wdata_o = {wbyte, wbyte}; wr_act_o = 2'b10; end
      default:   begin bus_wdata_o = {wbyte, wbyte}; wr_act_o = 2'b01; end
    endcase
  end

  assign rd_byte_o = (lane_o == LANE_LO) ? bus_i[LANE_W-1:0] : bus_i[DATA_W-1:LANE_W];
endmodule

// File: rtl/mbb_bus_ctrl.sv
module mbb_bus_ctrl
  import mbb_pkg::*;
#(
  parameter int N_AREA     = 4,
  parameter int ADDR_W     = 24,
  parameter int LANE_W     = 8,
  parameter int AREA_SHIFT = 16,
  parameter int WAIT_W     = 4,
  parameter bit DEF_WIDE   = 1'b1,
  localparam int DATA_W    = 2 * LANE_W,
  localparam int HI_W      = ADDR_W - AREA_SHIFT,
  localparam int IDX_W     = (N_AREA > 1) ? $clog2(N_AREA) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_area_i,
  input  logic              cfg_en_i,
  input  logic [HI_W-1:0]   cfg_base_i,
  input  logic [HI_W-1:0]   cfg_mask_i,
  input  logic              cfg_wide_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_half_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic              as_no,
  output logic              rd_no,
  output logic [1:0]        wr_no,
  output logic [N_AREA-1:0] cs_no,
  input  logic              rdy_i
);
  bus_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              write_q, half_q, wide_q, beat_q, rsp_q;
  logic [N_AREA-1:0] cs_oh_q, hit_oh;
  logic [WAIT_W-1:0] waits_q, cnt_q, hit_wait;
  logic              hit_wide, a0, last_beat, busy;
  lane_e             lane;
  logic [DATA_W-1:0] bus_wdata;
  logic [1:0]        wr_act;
  logic [LANE_W-1:0] rd_byte;

  mbb_area_regs #(
    .N_AREA(N_AREA), .HI_W(HI_W), .WAIT_W(WAIT_W), .DEF_WIDE(DEF_WIDE)
  ) u_areas (
    .clk_i, .rst_ni,
    .cfg_we_i, .cfg_area_i, .cfg_en_i, .cfg_base_i, .cfg_mask_i,
    .cfg_wide_i, .cfg_wait_i,
    .look_hi_i (req_addr_i[ADDR_W-1:AREA_SHIFT]),
    .hit_oh_o  (hit_oh),
    .wide_o    (hit_wide),
    .wait_o    (hit_wait)
  );

  assign a0 = half_q ? beat_q : addr_q[0];

  mbb_lane_steer #(.LANE_W(LANE_W)) u_lanes (
    .wide_i (wide_q), .half_i (half_q), .a0_i (a0), .beat_i (beat_q),
    .wdata_i (wdata_q), .bus_i (ad_i),
    .lane_o (lane), .bus_wdata_o (bus_wdata), .wr_act_o (wr_act), .rd_byte_o (rd_byte)
  );

  assign last_beat = wide_q || !half_q || beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      write_q <= 1'b0;
      half_q  <= 1'b0;
      wide_q  <= 1'b0;
      beat_q  <= 1'b0;
      rsp_q   <= 1'b0;
      cs_oh_q <= '0;
      waits_q <= '0;
      cnt_q   <= '0;
    end else begin
      rsp_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q  <= {req_addr_i[ADDR_W-1:1], req_addr_i[0] & ~req_half_i};
          wdata_q <= req_wdata_i;
          write_q <= req_write_i;
          half_q  <= req_half_i;
          cs_oh_q <= hit_oh;
          wide_q  <= hit_wide;
          waits_q <= hit_wait;
          beat_q  <= 1'b0;
          rdata_q <= '0;
          state_q <= ST_ADDR;
        end
        ST_ADDR: begin
          cnt_q   <= waits_q;
          state_q <= ST_DATA;
        end
        ST_DATA: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (rdy_i) begin
            if (!write_q) begin
              if (lane == LANE_BOTH)        rdata_q <= ad_i;
              else if (!half_q)             rdata_q <= {{LANE_W{1'b0}}, rd_byte};
              else if (!beat_q)             rdata_q[DATA_W-1:LANE_W] <= rd_byte;
              else                          rdata_q[LANE_W-1:0] <= rd_byte;
            end
            if (last_beat) begin
              state_q <= ST_IDLE;
              rsp_q   <= 1'b1;
            end else begin
              beat_q  <= 1'b1;
              state_q <= ST_ADDR;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = rsp_q;
  assign rsp_rdata_o = rdata_q;
  assign as_no       = (state_q != ST_ADDR);
  assign rd_no       = !(state_q == ST_DATA && !write_q);
  assign wr_no       = (state_q == ST_DATA && write_q) ? ~wr_act : 2'b11;
  assign cs_no       = busy ? ~cs_oh_q : '1;
  assign ad_oe_o     = (state_q == ST_ADDR) || (state_q == ST_DATA && write_q);
  assign addr_hi_o   = busy ? addr_q[ADDR_W-1:AREA_SHIFT] : '0;

  always_comb begin
    if (state_q == ST_ADDR)                 ad_o = {addr_q[DATA_W-1:1], a0};
    else if (state_q == ST_DATA && write_q) ad_o = bus_wdata;
    else                                    ad_o = '0;
  end

  assert_addr_one_clock_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_no |=> as_no);
  assert_rsp_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  assert_wait_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && cnt_q != '0) |=> (state_q == ST_DATA));
  assert_ready_stretch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && cnt_q == '0 && !rdy_i) |=> (state_q == ST_DATA && $stable(wr_no) && $stable(rd_no)));
  assert_cs_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));
  assert_read_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> (!ad_oe_o && wr_no == 2'b11));
endmodule

// File: tb/tb_mbb_bus_ctrl.sv
module tb_mbb_bus_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        cfg_we = 0, cfg_en = 0, cfg_wide = 0;
  logic [1:0]  cfg_area = 0;
  logic [7:0]  cfg_base = 0, cfg_mask = 0;
  logic [3:0]  cfg_wait = 0;
  logic        req_valid = 0, req_write = 0, req_half = 0;
  logic [23:0] req_addr = 0;
  logic [15:0] req_wdata = 0, ad_i = 0;
  logic        rdy_i = 1'b1;
  logic        req_ready, rsp_valid, ad_oe, as_n, rd_n;
  logic [15:0] rsp_rdata, ad_o;
  logic [7:0]  addr_hi;
  logic [1:0]  wr_n;
  logic [3:0]  cs_n;

  int n_chk = 0, n_fail = 0;

  bit         m_en [4];
  bit         m_wide [4];
  logic [7:0] m_base [4], m_mask [4];
  int         m_wait [4];

  always #(CLK_P/2) clk = ~clk;

  mbb_bus_ctrl dut (
    .clk_i(clk), .rst_ni,
    .cfg_we_i(cfg_we), .cfg_area_i(cfg_area), .cfg_en_i(cfg_en),
    .cfg_base_i(cfg_base), .cfg_mask_i(cfg_mask), .cfg_wide_i(cfg_wide), .cfg_wait_i(cfg_wait),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_half_i(req_half), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .addr_hi_o(addr_hi),
    .ad_o(ad_o), .ad_oe_o(ad_oe), .ad_i(ad_i), .as_no(as_n), .rd_no(rd_n),
    .wr_no(wr_n), .cs_no(cs_n), .rdy_i(rdy_i)
  );

  function automatic logic [34:0] pack(logic rdy, logic rsp, logic as, logic rd, logic [1:0] wr,
                                       logic [3:0] cs, logic oe, logic [15:0] ad, logic [7:0] hi);
    return {rdy, rsp, as, rd, wr, cs, oe, ad, hi};
  endfunction

  task automatic check_pins(input string tag, input logic [34:0] exp);
    logic [34:0] got;
    got = {req_ready, rsp_valid, as_n, rd_n, wr_n, cs_n, ad_oe, ad_o, addr_hi};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s pins got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_val(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s data got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int decode(logic [7:0] hi);
    for (int i = 0; i < 4; i++)
      if (m_en[i] && ((hi & m_mask[i]) == (m_base[i] & m_mask[i]))) return i;
    return -1;
  endfunction

  task automatic set_area(input int a, input bit en, input logic [7:0] base, input logic [7:0] mask,
                          input bit wide, input int w);
    @(negedge clk);
    cfg_we = 1; cfg_area = 2'(a); cfg_en = en; cfg_base = base; cfg_mask = mask;
    cfg_wide = wide; cfg_wait = 4'(w);
    m_en[a] = en; m_base[a] = base; m_mask[a] = mask; m_wide[a] = wide; m_wait[a] = w;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // optional same-clock config change (R10)
  bit         pc_on = 0;
  int         pc_area = 0, pc_wait = 0;

  task automatic xfer(input string tag, input bit wr, input logic [23:0] addr, input bit half,
                      input logic [15:0] wdata, input int stall);
    int area, waits, beats;
    bit wide;
    logic [23:0] ea;
    logic [3:0]  cs;
    logic [15:0] exp_rd, rv, bw;
    logic [7:0]  b;
    logic [1:0]  wexp;
    bit          odd;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = addr; req_half = half; req_wdata = wdata;
    area  = decode(addr[23:16]);
    wide  = (area < 0) ? 1'b1 : m_wide[area];
    waits = (area < 0) ? 0 : m_wait[area];
    if (pc_on) begin
      cfg_we = 1; cfg_area = 2'(pc_area); cfg_en = m_en[pc_area]; cfg_base = m_base[pc_area];
      cfg_mask = m_mask[pc_area]; cfg_wide = m_wide[pc_area]; cfg_wait = 4'(pc_wait);
      m_wait[pc_area] = pc_wait;
    end
    cs     = (area < 0) ? 4'hF : ~(4'b1 << area);
    beats  = (!wide && half) ? 2 : 1;
    ea     = half ? {addr[23:1], 1'b0} : addr;
    exp_rd = 16'h0;
    for (int bt = 0; bt < beats; bt++) begin
      @(negedge clk);
      req_valid = 0; cfg_we = 0; pc_on = 0;
      check_pins({tag, " addr"}, pack(0, 0, 0, 1, 2'b11, cs, 1,
                 {ea[15:1], half ? 1'(bt) : ea[0]}, ea[23:16]));
      if (wide && half) begin bw = wdata; wexp = 2'b00; end
      else begin
        b    = (half && bt == 0) ? wdata[15:8] : wdata[7:0];
        bw   = {b, b};
        odd  = wide && !half && ea[0];
        wexp = odd ? 2'b01 : 2'b10;
      end
      rv = 16'hC300 + 16'(bt) * 16'h0A00;
      for (int j = 0; j <= waits + stall; j++) begin
        @(negedge clk);
        rdy_i = (j < waits) ? 1'(j & 1) : (j == waits + stall);
        rv    = 16'hC300 + 16'(bt) * 16'h0A00 + 16'(j) * 16'h0111;
        ad_i  = rv;
        check_pins({tag, " data"}, pack(0, 0, 1, wr, wr ? wexp : 2'b11, cs, wr, wr ? bw : 16'h0, ea[23:16]));
      end
      if (!wr) begin
        if (wide && half)    exp_rd = rv;
        else if (!half)      exp_rd = {8'h00, (wide && ea[0]) ? rv[7:0] : rv[15:8]};
        else if (bt == 0)    exp_rd[15:8] = rv[15:8];
        else                 exp_rd[7:0]  = rv[15:8];
      end
    end
    @(negedge clk);
    rdy_i = 1; ad_i = 0;
    check_pins({tag, " done"}, pack(1, 1, 1, 1, 2'b11, 4'hF, 0, 16'h0, 8'h0));
    check_val({tag, " rdata"}, rsp_rdata, exp_rd);
  endtask

  bit done = 0;

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_en[i] = 0; m_wide[i] = 0; m_base[i] = 0; m_mask[i] = 0; m_wait[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check_pins("R1 reset", pack(1, 0, 1, 1, 2'b11, 4'hF, 0, 16'h0, 8'h0));
    check_val("R1 reset", rsp_rdata, 16'h0);

    set_area(0, 1, 8'h10, 8'hFF, 1, 0);
    set_area(1, 1, 8'h20, 8'hF0, 0, 2);
    set_area(2, 1, 8'h10, 8'hF0, 1, 3);
    set_area(3, 0, 8'h40, 8'hFF, 1, 1);

    xfer("R2 R7 wide half write", 1, 24'h10_1234, 1, 16'hBEEF, 0);
    xfer("R9 wide half read", 0, 24'h10_2000, 1, 16'h0, 0);
    xfer("R3 R7 even byte write", 1, 24'h12_0040, 0, 16'h00A5, 0);
    xfer("R7 odd byte write", 1, 24'h12_0041, 0, 16'h003C, 0);
    xfer("R4 odd byte read stall", 0, 24'h12_0041, 0, 16'h0, 2);
    xfer("R9 even byte read", 0, 24'h10_0006, 0, 16'h0, 0);
    xfer("R8 narrow half write", 1, 24'h25_0010, 1, 16'h1357, 1);
    xfer("R8 R11 narrow half read", 0, 24'h25_0011, 1, 16'h0, 0);
    xfer("R8 narrow byte odd", 1, 24'h2F_0003, 0, 16'h0081, 0);
    xfer("R6 disabled area write", 1, 24'h40_0000, 1, 16'h4242, 0);
    xfer("R6 unmapped read", 0, 24'h80_0001, 0, 16'h0, 1);
    xfer("R5 overlap low wins", 0, 24'h10_FFFE, 1, 16'h0, 0);
    xfer("R5 overlap second", 1, 24'h1F_0000, 1, 16'h7777, 0);
    xfer("R11 odd half write", 1, 24'h10_0103, 1, 16'hA1B2, 0);
    pc_on = 1; pc_area = 0; pc_wait = 5;
    xfer("R10 same clock cfg", 1, 24'h10_0200, 1, 16'h5A5A, 0);
    xfer("R10 new waits", 0, 24'h10_0202, 1, 16'h0, 1);
    xfer("R4 long stall", 1, 24'h20_0000, 0, 16'h00F0, 4);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule